// File: doc/BRIEF.md
# Tightly Coupled Instruction/Data Memory

This block is a small on-chip memory placed inside the processor boundary. It serves two requesters: the instruction fetch path and the load/store path. Each request address is compared against a fixed window, described by a base and a mask. An address inside the window always hits. It is served from the local array with no wait states: the request is accepted in the cycle it is presented, and the word and its acknowledge arrive on the next clock edge, so a new request can follow in every cycle. An address outside the window never hits. It goes out unchanged, in the same cycle, on a pass-through port toward the normal cache or bus path, so the cache is neither looked up nor filled for window traffic. Only the processor can reach the array; it has no port toward other bus masters.

The array is one word-wide store shared by both paths. In RAM mode, software fills it through the load/store port and can then fetch code from it. In ROM mode, its contents are computed at elaboration and writes are refused. The load/store port handles only full 32-bit words. If both paths hit the window in the same cycle, the load/store access takes the array and the fetch is held off for that cycle.

Top module: `tcm_window`

## Requirements
- R1: An address is inside the window exactly when (address & MASK) == (BASE & MASK). The defaults are BASE = 0x0001_0000 and MASK = 0xFFFF_FC00, which give a 256-word window. The word index is address bits [9:2].
- R2: A fetch outside the window raises `if_down_req` in the same cycle, with `if_down_addr` equal to `if_addr`. It produces no `if_ack`. A fetch inside the window leaves `if_down_req` low.
- R3: A load/store outside the window raises `dm_down_req` in the same cycle and copies write enable, address, write data and byte enables to the pass-through outputs. This applies to sub-word accesses too. It produces neither `dm_ack` nor `dm_err`.
- R4: A fetch inside the window that is not stalled gives `if_ack` and the addressed word on `if_rdata` one cycle later. Fetches can be issued back to back, one per cycle.
- R5: In RAM mode, a window write with `dm_be` == 4'b1111 stores `dm_wdata` and gives `dm_ack` one cycle later. The stored word is then returned to both the load/store path and the fetch path.
- R6: A full-word window read gives `dm_ack` and the word on `dm_rdata` one cycle later. Reads can be issued back to back, one per cycle.
- R7: When both paths hit the window in one cycle, the load/store access is served and `if_stall` is high in that cycle. No `if_ack` follows. A fetch re-presented in the next cycle is served, and it sees a write made by the access that won.
- R8: A window access with `dm_be` other than 4'b1111 gives a one-cycle `dm_err` one cycle later, no `dm_ack`, and no change to the array.
- R9: In ROM mode, word i holds (i * 0x9E3779B1) ^ 0xC0DE0000, truncated to 32 bits. A window write is not stored and gives `dm_err` instead of `dm_ack`.
- R10: While `rst_n` is low, `if_ack`, `dm_ack` and `dm_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| if_req | input | 1 | Fetch request |
| if_addr | input | 32 | Fetch byte address |
| if_stall | output | 1 | Fetch refused this cycle because of a load/store window hit |
| if_ack | output | 1 | Fetch data valid (one cycle after acceptance) |
| if_rdata | output | 32 | Fetched word |
| if_down_req | output | 1 | Fetch forwarded to the cache/bus path |
| if_down_addr | output | 32 | Forwarded fetch address |
| dm_req | input | 1 | Load/store request |
| dm_we | input | 1 | 1 = store, 0 = load |
| dm_addr | input | 32 | Load/store byte address |
| dm_be | input | 4 | Byte enables; only 4'b1111 is valid inside the window |
| dm_wdata | input | 32 | Store data |
| dm_ack | output | 1 | Load/store completed (one cycle after request) |
| dm_err | output | 1 | Window access refused (sub-word, or store in ROM mode) |
| dm_rdata | output | 32 | Load data |
| dm_down_req | output | 1 | Load/store forwarded to the cache/bus path |
| dm_down_we | output | 1 | Forwarded write enable |
| dm_down_addr | output | 32 | Forwarded address |
| dm_down_be | output | 4 | Forwarded byte enables |
| dm_down_wdata | output | 32 | Forwarded store data |

## Verification
The assertions check the timing relations on every cycle. A window hit on either path is answered exactly one cycle later. A forwarded request never draws a local response. A stall occurs only when the load/store path hits the window. The fetch and load/store responses never occur together. Sub-word accesses and ROM writes always end in an error and never in an acknowledge. Data correctness needs the bench's scenarios: full-array write and read sweeps on both paths, ROM contents against the formula, and read-after-write through an arbitration conflict. The same holds for proving that refused writes leave the array unchanged, and for the exact window edges.

// File: rtl/tcm_window.sv
module tcm_window #(
  parameter logic [31:0] BASE     = 32'h0001_0000,
  parameter logic [31:0] MASK     = 32'hFFFF_FC00,
  parameter int          DEPTH    = 256,
  parameter bit          ROM_MODE = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        if_req,
  input  logic [31:0] if_addr,
  output logic        if_stall,
  output logic        if_ack,
  output logic [31:0] if_rdata,
  output logic        if_down_req,
  output logic [31:0] if_down_addr,
  input  logic        dm_req,
  input  logic        dm_we,
  input  logic [31:0] dm_addr,
  input  logic [3:0]  dm_be,
  input  logic [31:0] dm_wdata,
  output logic        dm_ack,
  output logic        dm_err,
  output logic [31:0] dm_rdata,
  output logic        dm_down_req,
  output logic        dm_down_we,
  output logic [31:0] dm_down_addr,
  output logic [3:0]  dm_down_be,
  output logic [31:0] dm_down_wdata
);
  localparam int          IW     = $clog2(DEPTH);
  localparam logic [31:0] BASE_M = BASE & MASK;

  function automatic logic [31:0] rom_word(input int i);
    return (32'(i) * 32'h9E37_79B1) ^ 32'hC0DE_0000;
  endfunction

  logic [31:0]   mem [DEPTH];
  logic [31:0]   rd_q;
  logic [IW-1:0] idx;
  logic          if_hit, dm_hit, dm_sel, dm_bad, if_grant, dm_rd;

  assign if_hit   = (if_addr & MASK) == BASE_M;
  assign dm_hit   = (dm_addr & MASK) == BASE_M;
  assign dm_sel   = dm_req & dm_hit;
  assign dm_bad   = (dm_be != 4'hF) | (dm_we & ROM_MODE);
  assign dm_rd    = dm_sel & ~dm_we & ~dm_bad;
  assign if_grant = if_req & if_hit & ~dm_sel;
  assign if_stall = if_req & if_hit & dm_sel;
  assign idx      = dm_sel ? dm_addr[IW+1:2] : if_addr[IW+1:2];

  assign if_down_req   = if_req & ~if_hit;
  assign if_down_addr  = if_addr;
  assign dm_down_req   = dm_req & ~dm_hit;
  assign dm_down_we    = dm_we;
  assign dm_down_addr  = dm_addr;
  assign dm_down_be    = dm_be;
  assign dm_down_wdata = dm_wdata;

  generate
    if (ROM_MODE) begin : g_rom
      initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = rom_word(i);
      end
    end else begin : g_ram
      always_ff @(posedge clk) begin
        if (dm_sel && dm_we && !dm_bad) mem[idx] <= dm_wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (if_grant || dm_rd) rd_q <= mem[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      if_ack <= 1'b0;
      dm_ack <= 1'b0;
      dm_err <= 1'b0;
    end else begin
      if_ack <= if_grant;
      dm_ack <= dm_sel & ~dm_bad;
      dm_err <= dm_sel & dm_bad;
    end
  end

  assign if_rdata = rd_q;
  assign dm_rdata = rd_q;
endmodule

module tcm_window_chk #(
  parameter bit ROM_MODE = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       if_req,
  input logic       if_stall,
  input logic       if_ack,
  input logic       if_down_req,
  input logic       dm_req,
  input logic       dm_we,
  input logic [3:0] dm_be,
  input logic       dm_ack,
  input logic       dm_err,
  input logic       dm_down_req
);
  a_r4_hit_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (if_req && !if_down_req && !if_stall) |=> if_ack);
  a_r2_miss_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!if_req || if_down_req) |=> !if_ack);
  a_r7_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    if_stall |-> (if_req && !if_down_req && dm_req && !dm_down_req));
  a_r7_stall_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    if_stall |=> !if_ack);
  a_r7_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
    !(if_ack && (dm_ack || dm_err)));
  a_r6_hit_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_req && !dm_down_req) |=> $onehot({dm_ack, dm_err}));
  a_r3_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!dm_req || dm_down_req) |=> !(dm_ack || dm_err));
  a_r8_subword_err: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_req && !dm_down_req && dm_be != 4'hF) |=> (dm_err && !dm_ack));
  a_r9_rom_write_err: assert property (@(posedge clk) disable iff (!rst_n)
    (ROM_MODE && dm_req && dm_we && !dm_down_req) |=> (dm_err && !dm_ack));
  a_r10_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> !(if_ack || dm_ack || dm_err));
endmodule

bind tcm_window tcm_window_chk #(.ROM_MODE(ROM_MODE)) chk_i (
  .clk(clk), .rst_n(rst_n), .if_req(if_req), .if_stall(if_stall),
  .if_ack(if_ack), .if_down_req(if_down_req), .dm_req(dm_req), .dm_we(dm_we),
  .dm_be(dm_be), .dm_ack(dm_ack), .dm_err(dm_err), .dm_down_req(dm_down_req)
);

// File: tb/tcm_window_tb_top.sv
module tcm_window_tb_top;
  localparam logic [31:0] BASE = 32'h0001_0000;
  localparam int N = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int total = 0;
  int fails = 0;

  logic        if_req = 0, dm_req = 0, dm_we = 0;
  logic [31:0] if_addr = 0, dm_addr = 0, dm_wdata = 0;
  logic [3:0]  dm_be = 4'hF;
  logic        if_stall, if_ack, if_down_req, dm_ack, dm_err, dm_down_req, dm_down_we;
  logic [31:0] if_rdata, if_down_addr, dm_rdata, dm_down_addr, dm_down_wdata;
  logic [3:0]  dm_down_be;

  logic        r_if_req = 0, r_dm_req = 0, r_dm_we = 0;
  logic [31:0] r_if_addr = 0, r_dm_addr = 0, r_dm_wdata = 0;
  logic        r_if_stall, r_if_ack, r_if_down_req, r_dm_ack, r_dm_err, r_dm_down_req, r_dm_down_we;
  logic [31:0] r_if_rdata, r_if_down_addr, r_dm_rdata, r_dm_down_addr, r_dm_down_wdata;
  logic [3:0]  r_dm_down_be;

  tcm_window #(.ROM_MODE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .if_req(if_req), .if_addr(if_addr), .if_stall(if_stall),
    .if_ack(if_ack), .if_rdata(if_rdata), .if_down_req(if_down_req), .if_down_addr(if_down_addr),
    .dm_req(dm_req), .dm_we(dm_we), .dm_addr(dm_addr), .dm_be(dm_be), .dm_wdata(dm_wdata),
    .dm_ack(dm_ack), .dm_err(dm_err), .dm_rdata(dm_rdata), .dm_down_req(dm_down_req),
    .dm_down_we(dm_down_we), .dm_down_addr(dm_down_addr), .dm_down_be(dm_down_be),
    .dm_down_wdata(dm_down_wdata));

  tcm_window #(.ROM_MODE(1'b1)) dut_rom_i (
    .clk(clk), .rst_n(rst_n), .if_req(r_if_req), .if_addr(r_if_addr), .if_stall(r_if_stall),
    .if_ack(r_if_ack), .if_rdata(r_if_rdata), .if_down_req(r_if_down_req), .if_down_addr(r_if_down_addr),
    .dm_req(r_dm_req), .dm_we(r_dm_we), .dm_addr(r_dm_addr), .dm_be(4'hF), .dm_wdata(r_dm_wdata),
    .dm_ack(r_dm_ack), .dm_err(r_dm_err), .dm_rdata(r_dm_rdata), .dm_down_req(r_dm_down_req),
    .dm_down_we(r_dm_down_we), .dm_down_addr(r_dm_down_addr), .dm_down_be(r_dm_down_be),
    .dm_down_wdata(r_dm_down_wdata));

  function automatic logic [31:0] pat(input int i);
    return 32'h5A5A_0000 + 32'(i) * 32'h0001_0003;
  endfunction
  function automatic logic [31:0] rom_exp(input int i);
    return (32'(i) * 32'h9E37_79B1) ^ 32'hC0DE_0000;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  task automatic miss_case(input logic [31:0] a);
    @(negedge clk);
    if_req = 1; if_addr = a;
    dm_req = 1; dm_we = 1; dm_addr = a; dm_be = 4'b0110; dm_wdata = a ^ 32'hFFFF_0000;
    #1;
    check("R2 if_down_req", 32'(if_down_req), 1);
    check("R2 if_down_addr", if_down_addr, a);
    check("R3 dm_down_req", 32'(dm_down_req), 1);
    check("R3 dm_down_we", 32'(dm_down_we), 1);
    check("R3 dm_down_addr", dm_down_addr, a);
    check("R3 dm_down_be", 32'(dm_down_be), 32'h6);
    check("R3 dm_down_wdata", dm_down_wdata, a ^ 32'hFFFF_0000);
    check("R1 miss no stall", 32'(if_stall), 0);
    @(negedge clk);
    if_req = 0; dm_req = 0; dm_we = 0; dm_be = 4'hF;
    check("R2 miss no if_ack", 32'(if_ack), 0);
    check("R3 miss no ack/err", 32'({dm_ack, dm_err}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 if_ack in reset", 32'(if_ack), 0);
    check("R10 dm_ack in reset", 32'(dm_ack), 0);
    check("R10 dm_err in reset", 32'(dm_err), 0);
    rst_n = 1;

    // R5 write sweep over the whole window
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      if (i > 0) check("R5 write ack", 32'(dm_ack), 1);
      dm_req = 1; dm_we = 1; dm_be = 4'hF; dm_addr = BASE + 32'(4 * i); dm_wdata = pat(i);
      #1 check("R1 write hit not forwarded", 32'(dm_down_req), 0);
    end
    @(negedge clk);
    check("R5 last write ack", 32'(dm_ack), 1);
    dm_req = 0; dm_we = 0;

    // R6 back-to-back data reads
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check("R6 read ack", 32'(dm_ack), 1);
        check("R6 read data", dm_rdata, pat(i - 1));
      end
      dm_req = 1; dm_we = 0; dm_addr = BASE + 32'(4 * i);
    end
    @(negedge clk);
    check("R6 last read data", dm_rdata, pat(N - 1));
    dm_req = 0;

    // R4/R5 back-to-back fetches of the written words
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check("R4 fetch ack", 32'(if_ack), 1);
        check("R5 fetch sees stored word", if_rdata, pat(i - 1));
      end
      if_req = 1; if_addr = BASE + 32'(4 * i);
      #1 check("R2 hit not forwarded", 32'(if_down_req), 0);
    end
    @(negedge clk);
    check("R4 last fetch data", if_rdata, pat(N - 1));
    if_req = 0;

    // R1 window edges
    miss_case(BASE - 32'd4);
    miss_case(BASE + 32'h400);
    miss_case(BASE | 32'h8000_0000);
    @(negedge clk);
    if_req = 1; if_addr = BASE + 32'h3FC;
    @(negedge clk);
    if_req = 0;
    check("R1 top word hit ack", 32'(if_ack), 1);
    check("R1 top word data", if_rdata, pat(255));

    // R7 conflict with a read
    @(negedge clk);
    if_req = 1; if_addr = BASE + 32'd8;
    dm_req = 1; dm_we = 0; dm_addr = BASE + 32'd12;
    #1 check("R7 stall on conflict", 32'(if_stall), 1);
    @(negedge clk);
    check("R7 data wins ack", 32'(dm_ack), 1);
    check("R7 data wins rdata", dm_rdata, pat(3));
    check("R7 no fetch ack", 32'(if_ack), 0);
    dm_req = 0;
    #1 check("R7 stall released", 32'(if_stall), 0);
    @(negedge clk);
    check("R7 retried fetch ack", 32'(if_ack), 1);
    check("R7 retried fetch data", if_rdata, pat(2));
    if_req = 0;

    // R7 conflict with a write to the same word
    @(negedge clk);
    if_req = 1; if_addr = BASE + 32'd16;
    dm_req = 1; dm_we = 1; dm_be = 4'hF; dm_addr = BASE + 32'd16; dm_wdata = 32'hCAFE_F00D;
    #1 check("R7 stall on write conflict", 32'(if_stall), 1);
    @(negedge clk);
    check("R7 write ack", 32'(dm_ack), 1);
    check("R7 no fetch ack on write", 32'(if_ack), 0);
    dm_req = 0; dm_we = 0;
    @(negedge clk);
    check("R7 fetch sees new word", if_rdata, 32'hCAFE_F00D);
    if_req = 0;

    // R8 sub-word accesses inside the window
    for (int b = 0; b < 15; b++) begin
      @(negedge clk);
      dm_req = 1; dm_we = 1; dm_be = 4'(b); dm_addr = BASE + 32'd20; dm_wdata = 32'hDEAD_0000 + 32'(b);
      @(negedge clk);
      dm_req = 0; dm_we = 0; dm_be = 4'hF;
      check("R8 sub-word write err", 32'(dm_err), 1);
      check("R8 sub-word write no ack", 32'(dm_ack), 0);
    end
    @(negedge clk);
    check("R8 err is one pulse", 32'(dm_err), 0);
    dm_req = 1; dm_be = 4'b0001; dm_addr = BASE + 32'd20;
    @(negedge clk);
    check("R8 sub-word read err", 32'(dm_err), 1);
    dm_be = 4'hF;
    @(negedge clk);
    dm_req = 0;
    check("R8 array unchanged", dm_rdata, pat(5));

    // R9 ROM contents through the fetch path
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check("R9 rom fetch ack", 32'(r_if_ack), 1);
        check("R9 rom word", r_if_rdata, rom_exp(i - 1));
      end
      r_if_req = 1; r_if_addr = BASE + 32'(4 * i);
    end
    @(negedge clk);
    check("R9 rom last word", r_if_rdata, rom_exp(N - 1));
    r_if_req = 0;

    // R9 ROM write refused, contents kept
    @(negedge clk);
    r_dm_req = 1; r_dm_we = 1; r_dm_addr = BASE + 32'd40; r_dm_wdata = 32'h1234_5678;
    @(negedge clk);
    check("R9 rom write err", 32'(r_dm_err), 1);
    check("R9 rom write no ack", 32'(r_dm_ack), 0);
    r_dm_we = 0;
    @(negedge clk);
    r_dm_req = 0;
    check("R9 rom read ack", 32'(r_dm_ack), 1);
    check("R9 rom word kept", r_dm_rdata, rom_exp(10));

    @(negedge clk);
    finish_run();
  end
endmodule